// File: doc/BRIEF.md
# Bidirectional I/O Port with Change Interrupt

The block is an eight-bit general-purpose I/O port. Each bit can be set as an input or an output through a direction register. A written output latch drives the pins. A shared, active-low enable turns on a weak pull-up on every pin that is set as an input. Software reaches the port through a small register bus. A read of the data register returns the levels seen on the pins after a two-flop synchronizer.

For change detection the block keeps a reference copy of the port. Every pin that is set as an input is compared with its reference bit on every cycle. Any difference sets a level interrupt flag, and the flag also drives a wake output.

Reading the data register copies the current pin levels into the reference, and writing the data register copies the written value into it. Either access ends the mismatch. After that, software clears the flag by writing a one to the clear register. This arrangement suits a key matrix that must wake the system when a key is pressed.

Top module: `gpio_cport`

## Requirements
- R1: A direction bit of 1 makes its pin an input and a 0 makes it an output. The direction register sits at address 1, and `pin_oe` is the bitwise inverse of it one cycle after the write.
- R2: A write to address 0 loads the output latch, and `pin_out` shows the written value one cycle after the write.
- R3: A read strobe returns, on `bus_rdata` one cycle later, the following values:
  - at address 0, the synchronized pin levels;
  - at address 1, the direction register;
  - at address 2, the control register in bit 0;
  - at address 3, the interrupt flag in bit 0.
- R4: Bit 0 of the control register at address 2 is an active-low pull-up enable. `pin_pu[i]` is 1 exactly when that bit is 0 and pin i is an input, so a pin set as an output never has its pull-up on.
- R5: Reset is synchronous and active-high. It sets the following state:
  - all direction bits to 1 (inputs);
  - the output latch, the control bit, the reference and the flag to 0;
  - as a result, all pull-ups on.
- R6: Pins set as outputs take no part in the change comparison. A level change on such a pin never sets the flag.
- R7: The flag is set on every cycle in which any input pin differs from its reference bit. While a mismatch persists, a clear request leaves the flag set.
- R8: Writing address 3 with bit 0 equal to 1 clears the flag when no mismatch exists. Writing bit 0 equal to 0 has no effect on the flag.
- R9: A read of address 0 loads the reference with the synchronized pin levels. A write of address 0 loads the reference with the written value.
- R10: `wake` is 1 exactly when the flag is 1.
- R11: A level change on an input pin reaches `irq_flag` at the third rising clock edge after the change: two synchronizer stages, then the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 data, 1 direction, 2 control, 3 flag) |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, valid the cycle after `bus_re` |
| pin_in | input | W | Raw pin levels |
| pin_out | output | W | Output latch toward the pad drivers |
| pin_oe | output | W | Per-pin output enable (1 = drive) |
| pin_pu | output | W | Per-pin weak pull-up enable |
| irq_flag | output | 1 | Level change-interrupt flag |
| wake | output | 1 | Wake request, follows the flag |

## Verification
The assertions check the following on every cycle:
- how direction writes reach the output enables;
- how data writes reach the output latch;
- how control writes reach the pull-ups;
- that a mismatch always sets the flag on the next cycle;
- that a clear without a mismatch always empties the flag.

Some behaviour only the bench scenarios can show. These are the exact three-edge latency from a pin change to the flag, and the fact that an output pin toggling leaves the flag alone. They also include the read-then-clear sequence that ends a change condition and the values returned by each register read.

// File: rtl/gpio_cport_pkg.sv
package gpio_cport_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_cport_sync.sv
module gpio_cport_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpio_cport_regs.sv
module gpio_cport_regs
  import gpio_cport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic         pu_dis_q,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q    <= '0;
      dir_q    <= '1;
      pu_dis_q <= 1'b0;
    end else if (we) begin
      case (sel)
        SEL_DATA: out_q    <= wdata;
        SEL_DIR:  dir_q    <= wdata;
        SEL_CTRL: pu_dis_q <= wdata[0];
        default:  ;
      endcase
    end
  end

  assign pin_oe = ~dir_q;
  assign pin_pu = dir_q & {W{~pu_dis_q}};
endmodule

// File: rtl/gpio_cport_chg.sv
module gpio_cport_chg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_s,
  input  logic [W-1:0] dir,
  input  logic         snap_rd,
  input  logic         snap_wr,
  input  logic [W-1:0] wdata,
  input  logic         clr_req,
  output logic [W-1:0] mism,
  output logic         flag_q
);
  logic [W-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (rst)          ref_q <= '0;
    else if (snap_wr) ref_q <= wdata;
    else if (snap_rd) ref_q <= pins_s;
  end

  assign mism = dir & (pins_s ^ ref_q);

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (|mism)   flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end
endmodule

// File: rtl/gpio_cport.sv
module gpio_cport
  import gpio_cport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_we,
  input  logic         bus_re,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu,
  output logic         irq_flag,
  output logic         wake
);
  localparam int SYNC_STAGES = 2;

  reg_sel_e     sel;
  logic [W-1:0] pins_s;
  logic [W-1:0] out_q;
  logic [W-1:0] dir_q;
  logic         pu_dis_q;
  logic [W-1:0] mism;
  logic         flag_q;
  logic [W-1:0] rd_mux;

  assign sel = reg_sel_e'(bus_addr);

  gpio_cport_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pins_s)
  );

  gpio_cport_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .wdata(bus_wdata),
    .out_q(out_q), .dir_q(dir_q), .pu_dis_q(pu_dis_q),
    .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  gpio_cport_chg #(.W(W)) u_chg (
    .clk(clk), .rst(rst), .pins_s(pins_s), .dir(dir_q),
    .snap_rd(bus_re && sel == SEL_DATA),
    .snap_wr(bus_we && sel == SEL_DATA),
    .wdata(bus_wdata),
    .clr_req(bus_we && sel == SEL_FLAG && bus_wdata[0]),
    .mism(mism), .flag_q(flag_q)
  );

  always_comb begin
    case (sel)
      SEL_DATA: rd_mux = pins_s;
      SEL_DIR:  rd_mux = dir_q;
      SEL_CTRL: rd_mux = {{(W-1){1'b0}}, pu_dis_q};
      default:  rd_mux = {{(W-1){1'b0}}, flag_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assign pin_out  = out_q;
  assign irq_flag = flag_q;
  assign wake     = flag_q;
endmodule

// File: rtl/gpio_cport_chk.sv
module gpio_cport_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_we,
  input logic [1:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_pu,
  input logic         irq_flag,
  input logic [W-1:0] mism
);
  p_dir_oe_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd1) |=> (pin_oe == ~$past(bus_wdata)));

  p_out_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd0) |=> (pin_out == $past(bus_wdata)));

  p_pullup_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd2) |=>
      (pin_pu == ($past(bus_wdata[0]) ? '0 : ~pin_oe)));

  p_reset_state_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_pu == '1 && pin_oe == '0 && !irq_flag));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (|mism) |=> irq_flag);

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 2'd3 && bus_wdata[0] && !(|mism)) |=> !irq_flag);
endmodule

bind gpio_cport gpio_cport_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .pin_pu(pin_pu), .irq_flag(irq_flag), .mism(mism)
);

// File: tb/sim_gpio_cport.sv
`timescale 1ns/1ps
module sim_gpio_cport;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_we = 1'b0;
  logic         bus_re = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe, pin_pu;
  logic         irq_flag, wake;

  int n_run = 0;
  int n_fail = 0;
  logic rd_q = 1'b0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #4 clk = ~clk;

  gpio_cport #(.W(W)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .irq_flag(irq_flag), .wake(wake)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [W-1:0] exp, string tag);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) rd_q <= bus_re;

  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R3: unexpected read actual %0h expected none", bus_rdata);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(t, bus_rdata, e);
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    // R5 reset state
    chk("R5 oe", pin_oe, 8'h00);
    chk("R5 pu", pin_pu, 8'hFF);
    chk("R5 flag", irq_flag, 0);
    chk("R5 out", pin_out, 8'h00);
    rd(2'd1, 8'hFF, "R5 dir read");
    rd(2'd2, 8'h00, "R3 ctrl read");

    // R1 / R2 / R4
    wr(2'd1, 8'h0F);
    chk("R1 oe", pin_oe, 8'hF0);
    chk("R4 pu inputs only", pin_pu, 8'h0F);
    wr(2'd0, 8'hA5);
    chk("R2 out", pin_out, 8'hA5);
    wr(2'd2, 8'h01);
    chk("R4 pu off", pin_pu, 8'h00);
    wr(2'd2, 8'h00);
    chk("R4 pu on", pin_pu, 8'h0F);

    // R9 write loaded reference A5 against pins 00 -> mismatch
    rd(2'd0, 8'h00, "R3 data read");
    chk("R9 write mismatch flag", irq_flag, 1);
    chk("R10 wake set", wake, 1);
    wr(2'd3, 8'h01);
    chk("R8 clear", irq_flag, 0);
    chk("R10 wake clear", wake, 0);

    // R6 output pin change ignored
    @(negedge clk) pin_in = 8'h80;
    idle(5);
    chk("R6 output pin excluded", irq_flag, 0);
    rd(2'd3, 8'h00, "R6 flag read");

    // R11 latency
    @(negedge clk) pin_in = 8'h82;
    idle(2);
    chk("R11 not before third edge", irq_flag, 0);
    idle(1);
    chk("R11 at third edge", irq_flag, 1);

    // R7 clear ignored while mismatch persists
    wr(2'd3, 8'h01);
    chk("R7 sticky", irq_flag, 1);
    rd(2'd0, 8'h82, "R9 read snapshot");
    wr(2'd3, 8'h01);
    chk("R9 read ends mismatch", irq_flag, 0);

    // R9 write path
    wr(2'd0, 8'h00);
    idle(1);
    chk("R9 write sets reference", irq_flag, 1);
    wr(2'd0, 8'h02);
    wr(2'd3, 8'h01);
    chk("R9 write ends mismatch", irq_flag, 0);

    // R8 writing 0 has no effect
    @(negedge clk) pin_in = 8'h83;
    idle(3);
    chk("R7 new mismatch", irq_flag, 1);
    rd(2'd0, 8'h83, "R3 data read 83");
    wr(2'd3, 8'h00);
    chk("R8 zero write ignored", irq_flag, 1);
    rd(2'd3, 8'h01, "R3 flag read");
    wr(2'd3, 8'h01);
    chk("R8 clear after read", irq_flag, 0);
    rd(2'd1, 8'h0F, "R1 dir read");
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule